// File: doc/BRIEF.md
# Memory Access Permission Checker

This combinational block decides, in the same cycle it is asked, whether a single memory access may go ahead. The access arrives as a start address, a byte count, a one-hot request for read, write or execute, and the privilege level of the requester. A set of protection entries also comes in. Each entry has already been decoded into an inclusive low and high byte bound, and carries a small configuration field and a lock flag. The block produces one allow bit. Raising a fault on a deny is left to the surrounding pipeline.

Entries are searched from index 0 upward. The lowest-numbered active entry that holds any byte of the access settles the answer. An access that lies only partly inside that entry is refused. Requesters below machine level must find every requested right in the entry's permission bits. Machine level skips that check except on locked entries. When no entry claims the access, the result depends on the privilege level and on whether any entry is active at all.

Top module: `pmp_access_check`

## Requirements
- R1: When every entry is in the off mode (configuration bits [4:3] equal to 0), every access is allowed, whatever its address, size, request or privilege.
- R2: An entry in the off mode never claims an access, even when its bounds cover the access.
- R3: Entries are examined from index 0 upward. The lowest-indexed active entry that holds the first byte or the last byte of the access alone decides the result, and higher entries are not consulted.
- R4: If the deciding entry holds exactly one of the first and last bytes, the access is denied at every privilege level.
- R5: For privilege 0 (user) or 1 (supervisor), an access fully inside the deciding entry is allowed only when each requested right is set in that entry's configuration. Bit 0 grants read, bit 1 grants write and bit 2 grants execute, and the request uses the same positions, one-hot.
- R6: For privilege 3 (machine), an access fully inside an unlocked deciding entry is allowed whatever that entry's permission bits hold.
- R7: For privilege 3, an access fully inside a locked deciding entry is checked against the permission bits exactly as in R5.
- R8: When at least one entry is active and none claims the access, privilege 3 is allowed and every other privilege is denied.
- R9: The last byte of an access is the start address plus the size minus 1, taken modulo 2^ADDR_W. Both entry bounds are inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | SIZE_W | Access length in bytes, at least 1 |
| req_perm | input | 3 | One-hot requested right: bit 0 read, bit 1 write, bit 2 execute |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| ent_lo | input | NUM_ENTRIES*ADDR_W | Inclusive low bound per entry, entry i at [i*ADDR_W +: ADDR_W] |
| ent_hi | input | NUM_ENTRIES*ADDR_W | Inclusive high bound per entry |
| ent_cfg | input | NUM_ENTRIES*5 | Per entry: bits [2:0] rights, bits [4:3] match mode (0 = off) |
| ent_locked | input | NUM_ENTRIES | Per-entry lock status |
| access_ok | output | 1 | 1 when the access is allowed |

## Verification
The bench uses two overlapping entries with different rights to test priority. A design that let a later entry override an earlier one, or that took the most permissive match, would allow a write that the lower entry forbids. Accesses that straddle a bound by one byte, in both directions, catch off-by-one errors in the last-byte arithmetic and bounds that are not inclusive. Such a design would either accept a straddle or reject an access that exactly fills an entry. An active entry whose bounds cover the access is switched to off to expose a design that matches on bounds alone. Machine-level accesses are made to both locked and unlocked entries, because a design that confused the two would either grant execute on a locked region or deny a write on an unlocked one.

// File: rtl/pmp_access_check.sv
module pmp_access_check #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 4
) (
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [SIZE_W-1:0]             req_size,
  input  logic [2:0]                    req_perm,
  input  logic [1:0]                    req_priv,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_lo,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_hi,
  input  logic [NUM_ENTRIES*5-1:0]      ent_cfg,
  input  logic [NUM_ENTRIES-1:0]        ent_locked,
  output logic                          access_ok
);
  localparam int CFG_W = 5;
  localparam logic [1:0] PRIV_M = 2'd3;

  logic [ADDR_W-1:0]      last_byte;
  logic [NUM_ENTRIES-1:0] active, first_in, last_in, touch, full, sel;
  logic                   any_active, is_m;
  logic                   ch_full, ch_lock;
  logic [2:0]             ch_rwx;
  logic                   perm_ok;

  assign last_byte = req_addr + ADDR_W'(req_size) - ADDR_W'(1);
  assign is_m      = (req_priv == PRIV_M);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic [ADDR_W-1:0] lo, hi;
    assign lo          = ent_lo[i*ADDR_W +: ADDR_W];
    assign hi          = ent_hi[i*ADDR_W +: ADDR_W];
    assign active[i]   = |ent_cfg[i*CFG_W+3 +: 2];
    assign first_in[i] = active[i] && (req_addr >= lo) && (req_addr <= hi);
    assign last_in[i]  = active[i] && (last_byte >= lo) && (last_byte <= hi);
  end

  assign touch      = first_in | last_in;
  assign full       = first_in & last_in;
  assign sel        = touch & (~touch + NUM_ENTRIES'(1));
  assign any_active = |active;

  always_comb begin
    ch_full = 1'b0;
    ch_lock = 1'b0;
    ch_rwx  = 3'b000;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (sel[i]) begin
        ch_full = full[i];
        ch_lock = ent_locked[i];
        ch_rwx  = ent_cfg[i*CFG_W +: 3];
      end
    end
  end

  assign perm_ok = ((req_perm & ~ch_rwx) == 3'b000);

  always_comb begin
    if (!any_active)          access_ok = 1'b1;
    else if (sel == '0)       access_ok = is_m;
    else if (!ch_full)        access_ok = 1'b0;
    else if (is_m && !ch_lock) access_ok = 1'b1;
    else                      access_ok = perm_ok;
  end

  always_comb begin
    p_all_off_allows_r1: assert (any_active || access_ok);
    p_single_winner_r3: assert ($onehot0(sel));
    p_off_never_wins_r2: assert ((sel & ~active) == '0);
    p_straddle_denied_r4: assert (!((sel != '0) && ((sel & full) == '0) && any_active) || !access_ok);
    p_nomatch_default_r8: assert (!(any_active && touch == '0) || (access_ok == is_m));
    p_unlocked_machine_r6: assert (!(any_active && (sel & full) != '0 && is_m && !ch_lock) || access_ok);
  end
endmodule

// File: tb/pmp_access_check_tb.sv
module pmp_access_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int SW = 4;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  size;
    logic [2:0]  perm;
    logic [1:0]  priv;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam logic [2:0] PR = 3'b001, PW = 3'b010, PX = 3'b100;
  localparam logic [1:0] U = 2'd0, S = 2'd1, M = 2'd3;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 4'd4, PR, U, 1'b1, 8'd5},  // R5 read granted
    '{32'h1000, 4'd4, PW, U, 1'b0, 8'd5},  // R5 write refused
    '{32'h1000, 4'd4, PW, M, 1'b1, 8'd6},  // R6 machine, unlocked
    '{32'h10FC, 4'd4, PW, U, 1'b0, 8'd3},  // R3 entry 0 wins over entry 1
    '{32'h10FE, 4'd4, PR, U, 1'b0, 8'd4},  // R4 straddle high side of entry 0
    '{32'h1100, 4'd4, PW, U, 1'b1, 8'd3},  // R3 falls to entry 1
    '{32'h1100, 4'd4, PX, M, 1'b0, 8'd7},  // R7 locked, machine, X missing
    '{32'h2000, 4'd8, PX, S, 1'b1, 8'd5},  // R5 execute granted
    '{32'h2000, 4'd8, PR, M, 1'b0, 8'd7},  // R7 locked, read missing
    '{32'h3000, 4'd4, PR, U, 1'b0, 8'd2},  // R2 off entry ignored
    '{32'h3000, 4'd4, PR, M, 1'b1, 8'd8},  // R8 machine default
    '{32'h10FC, 4'd4, PR, U, 1'b1, 8'd9},  // R9 fills to inclusive bound
    '{32'h10FD, 4'd4, PR, U, 1'b0, 8'd9},  // R9 one byte past bound
    '{32'h0FFF, 4'd2, PR, U, 1'b0, 8'd4},  // R4 straddle low side
    '{32'h0FFC, 4'd4, PR, U, 1'b0, 8'd9},  // R9 ends just below bound
    '{32'h2FFF, 4'd1, PX, U, 1'b1, 8'd9},  // R9 single byte at top bound
    '{32'h5000, 4'd4, PR, S, 1'b0, 8'd8}   // R8 supervisor default deny
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0]   req_addr;
  logic [SW-1:0]   req_size;
  logic [2:0]      req_perm;
  logic [1:0]      req_priv;
  logic [N*AW-1:0] ent_lo, ent_hi;
  logic [N*5-1:0]  ent_cfg;
  logic [N-1:0]    ent_locked;
  logic            access_ok;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  pmp_access_check #(.NUM_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW)) dut_i (
    .req_addr(req_addr), .req_size(req_size), .req_perm(req_perm), .req_priv(req_priv),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg), .ent_locked(ent_locked),
    .access_ok(access_ok)
  );

  task automatic set_ent(int i, logic [31:0] lo, logic [31:0] hi, logic [1:0] mode,
                         logic [2:0] rwx, logic lk);
    ent_lo[i*AW +: AW] = lo;
    ent_hi[i*AW +: AW] = hi;
    ent_cfg[i*5 +: 5]  = {mode, rwx};
    ent_locked[i]      = lk;
  endtask

  task automatic apply(logic [31:0] a, logic [3:0] sz, logic [2:0] p, logic [1:0] pv,
                       logic exp, int rq);
    req_addr = a; req_size = sz; req_perm = p; req_priv = pv;
    #1;
    n_chk++;
    if (access_ok !== exp) begin
      n_fail++;
      $display("FAIL R%0d addr=%h size=%0d perm=%b priv=%0d: got %b expected %b",
               rq, a, sz, p, pv, access_ok, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) set_ent(i, 32'h0, 32'h0, 2'd0, 3'b000, 1'b0);
  endtask

  task automatic standard_map();
    clear_all();
    set_ent(0, 32'h1000, 32'h10FF, 2'd1, 3'b001, 1'b0);
    set_ent(1, 32'h1080, 32'h11FF, 2'd1, 3'b011, 1'b1);
    set_ent(2, 32'h2000, 32'h2FFF, 2'd3, 3'b100, 1'b1);
    set_ent(3, 32'h3000, 32'h3FFF, 2'd0, 3'b111, 1'b0);
  endtask

  initial begin
    req_addr = '0; req_size = 4'd1; req_perm = PR; req_priv = U;
    clear_all();
    @(negedge clk);
    // R1: idle state with every entry off allows everything
    apply(32'h0000_0000, 4'd1, PR, U, 1'b1, 1);
    apply(32'hFFFF_FFF0, 4'd8, PW, S, 1'b1, 1);
    apply(32'h1234_5678, 4'd4, PX, U, 1'b1, 1);
    // R1: off entries with matching bounds still allow
    set_ent(5, 32'h1000, 32'h10FF, 2'd0, 3'b000, 1'b1);
    apply(32'h1000, 4'd4, PW, U, 1'b1, 1);

    standard_map();
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      apply(VECS[k].addr, VECS[k].size, VECS[k].perm, VECS[k].priv, VECS[k].exp, int'(VECS[k].req));
    end

    // R7: locking entry 0 makes machine write obey its read-only rights
    @(negedge clk);
    set_ent(0, 32'h1000, 32'h10FF, 2'd1, 3'b001, 1'b1);
    apply(32'h1000, 4'd4, PW, M, 1'b0, 7);
    // R2: turning entry 0 off hands the access to entry 1 (RW)
    set_ent(0, 32'h1000, 32'h10FF, 2'd0, 3'b001, 1'b0);
    apply(32'h10FC, 4'd4, PW, U, 1'b1, 2);
    // R4: machine level is also refused on a straddle
    apply(32'h11FE, 4'd4, PR, M, 1'b0, 4);
    // R9: last byte wraps modulo the address width into entry 6
    set_ent(6, 32'h0000_0000, 32'h0000_000F, 2'd1, 3'b111, 1'b0);
    apply(32'hFFFF_FFFE, 4'd4, PR, U, 1'b0, 9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule